// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block is the configuration front end of a video processing core. Software reaches it through a simple word-addressed read/write port. Each configuration word has two copies. A write always lands in the staged copy. The staged copies move into the active copies, which drive the core, only on a rising edge of the start-of-frame input. That move happens only while the control word has both its enable bit and its update-permit bit set. Software can therefore rewrite many coefficients mid-frame without the datapath seeing a half-updated set.

The configuration space holds the following words:
- a frame-size word;
- a frame-encoding word;
- two horizontal coefficient phases of 24 words each;
- two vertical coefficient phases of 8 words each.

All tap and phase counts are parameters.

Two reset controls sit beside the normal bits:
- An immediate reset clears every configuration copy at once. It keeps the core reset output high until software clears the bit.
- A frame-aligned reset waits for the next start-of-frame edge. There it clears every configuration copy and the control word, and gives a one-cycle core reset pulse. Normal operation then resumes with no further write.

Top module: `frame_shadow_regs`

## Requirements
- R1: After rst_ni is released, rdata_o, enable_o, core_rst_o and every active configuration output are zero, and every register reads zero except the version word.
- R2: A write to a configuration offset updates the staged copy. A read of the same offset returns the staged value on rdata_o from the clock edge that samples rd_en_i.
- R3: The active copies take the staged values at the clock edge where sof_i is first seen high after being low, when control bit 0 (enable) and bit 1 (update permit) are both set. The new values are visible on the outputs after that edge.
- R4: While either control bit 0 or bit 1 is clear, a start-of-frame edge leaves every active output unchanged, though the staged writes are kept.
- R5: Exactly one commit happens per rising edge of sof_i. Staged writes made while sof_i stays high reach the outputs only at the next rising edge.
- R6: While control bit 31 is set, all staged and active words are held at zero, configuration writes are dropped, and core_rst_o is high. Clearing the bit releases core_rst_o.
- R7: With control bit 30 set, the next start-of-frame edge clears all configuration words and the control word, and drives core_rst_o high for exactly one cycle. No commit happens at that edge.
- R8: Status (offset 0x004) bit 0 mirrors control bit 0. Status bit 1 is set by a commit and cleared by a read of the status word; that read still returns the set value.
- R9: Offsets that are not mapped read zero and ignore writes. The control word keeps only bits 0, 1, 30 and 31. Offset 0x010 reads the VERSION_ID parameter.
- R10: Byte offsets are fixed as follows:
  - 0x000: control word.
  - 0x020: frame size.
  - 0x028: frame encoding.
  - 0x100 upward: horizontal coefficients, phase-major, 4 bytes per word.
  - 0x1C0 upward: vertical coefficients, phase-major, 4 bytes per word.
  - The error, interrupt-enable and debug offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| sof_i | input | 1 | Start-of-frame level |
| enable_o | output | 1 | Core enable (control bit 0) |
| core_rst_o | output | 1 | Core reset / hold |
| frame_size_o | output | 32 | Active frame-size word |
| encoding_o | output | 32 | Active encoding word |
| hcoef_o | output | H_PHASES*H_TAPS*32 | Active horizontal coefficients, word 0 in the low bits |
| vcoef_o | output | V_PHASES*V_TAPS*32 | Active vertical coefficients, word 0 in the low bits |

## Verification
The bench holds sof_i high for several cycles while rewriting a staged word. A design that commits on the level instead of the edge would leak that value early.

It also arms each control bit on its own and pulses start-of-frame. A design that commits on enable alone, or on permit alone, would change the outputs when they must stay fixed.

The frame-aligned reset is checked for the exact cycle of its one-cycle pulse and for a control word that reads back zero. A design that stays in reset, or forgets to clear the control word, fails there.

Reads of the status word check that the commit flag survives until it is read and clears only through that read.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned REG_W = 32;

  // control bit positions, decoded by the core
  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_UPD = 1;
  localparam int unsigned CB_FSR = 30;
  localparam int unsigned CB_IMM = 31;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'hC000_0003;

  // word indices of fixed registers
  localparam int unsigned W_CTRL = 'h00;
  localparam int unsigned W_STAT = 'h01;
  localparam int unsigned W_VER  = 'h04;
  localparam int unsigned W_SIZE = 'h08;
  localparam int unsigned W_ENC  = 'h0A;
  localparam int unsigned W_HCO  = 'h40;

  typedef enum logic [2:0] {
    K_NONE,
    K_CTRL,
    K_STAT,
    K_VER,
    K_CFG
  } reg_kind_e;
endpackage

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned H_WORDS = 48,
  parameter int unsigned V_WORDS = 16,
  parameter int unsigned IDX_W   = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned V_BASE = W_HCO + H_WORDS;

  int w;

  always_comb begin
    w      = int'(addr_i[ADDR_W-1:2]);
    kind_o = K_NONE;
    idx_o  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (w == W_CTRL)      kind_o = K_CTRL;
      else if (w == W_STAT) kind_o = K_STAT;
      else if (w == W_VER)  kind_o = K_VER;
      else if (w == W_SIZE) begin
        kind_o = K_CFG;
        idx_o  = IDX_W'(0);
      end else if (w == W_ENC) begin
        kind_o = K_CFG;
        idx_o  = IDX_W'(1);
      end else if (w >= W_HCO && w < V_BASE) begin
        kind_o = K_CFG;
        idx_o  = IDX_W'(w - W_HCO + 2);
      end else if (w >= V_BASE && w < V_BASE + V_WORDS) begin
        kind_o = K_CFG;
        idx_o  = IDX_W'(w - V_BASE + 2 + H_WORDS);
      end
    end
  end
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             ctrl_wr_i,
  input  logic             stat_rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             sof_pulse_o,
  output logic             commit_o,
  output logic             cfg_clr_o,
  output logic             core_rst_o,
  output logic             sticky_o
);
  logic             sof_q, fire_q, sticky_q, fsync_fire;
  logic [REG_W-1:0] ctrl_q;

  assign sof_pulse_o = sof_i & ~sof_q;
  assign fsync_fire  = ctrl_q[CB_FSR] & sof_pulse_o;
  // a pending reset of either kind takes the frame edge instead of a commit
  assign commit_o    = sof_pulse_o & ctrl_q[CB_EN] & ctrl_q[CB_UPD]
                     & ~ctrl_q[CB_IMM] & ~ctrl_q[CB_FSR];
  assign cfg_clr_o   = ctrl_q[CB_IMM] | fsync_fire;
  assign core_rst_o  = ctrl_q[CB_IMM] | fire_q;
  assign ctrl_o      = ctrl_q;
  assign sticky_o    = sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_q    <= 1'b0;
      fire_q   <= 1'b0;
      sticky_q <= 1'b0;
      ctrl_q   <= '0;
    end else begin
      sof_q  <= sof_i;
      fire_q <= fsync_fire;
      if (fsync_fire)     ctrl_q <= '0;
      else if (ctrl_wr_i) ctrl_q <= wdata_i & CTRL_KEEP;
      if (commit_o)       sticky_q <= 1'b1;
      else if (stat_rd_i) sticky_q <= 1'b0;
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int unsigned N     = 66,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             commit_i,
  output logic [N*W-1:0]   staged_o,
  output logic [N*W-1:0]   active_o
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] stg_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= '0;
        act_q <= '0;
      end else if (clr_i) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_i && widx_i == IDX_W'(g)) stg_q <= wdata_i;
        if (commit_i)                    act_q <= stg_q;
      end
    end

    assign staged_o[g*W +: W] = stg_q;
    assign active_o[g*W +: W] = act_q;
  end
endmodule

// File: rtl/frame_shadow_regs.sv
module frame_shadow_regs
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned H_TAPS     = 24,
  parameter int unsigned H_PHASES   = 2,
  parameter int unsigned V_TAPS     = 8,
  parameter int unsigned V_PHASES   = 2,
  parameter logic [31:0] VERSION_ID = 32'h0300_0001,
  localparam int unsigned HC_BITS   = H_TAPS * H_PHASES * 32,
  localparam int unsigned VC_BITS   = V_TAPS * V_PHASES * 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               sof_i,
  output logic               enable_o,
  output logic               core_rst_o,
  output logic [31:0]        frame_size_o,
  output logic [31:0]        encoding_o,
  output logic [HC_BITS-1:0] hcoef_o,
  output logic [VC_BITS-1:0] vcoef_o
);
  localparam int unsigned H_WORDS = H_TAPS * H_PHASES;
  localparam int unsigned V_WORDS = V_TAPS * V_PHASES;
  localparam int unsigned N_CFG   = 2 + H_WORDS + V_WORDS;
  localparam int unsigned IDX_W   = $clog2(N_CFG);

  reg_kind_e              kind;
  logic [IDX_W-1:0]       idx;
  logic [REG_W-1:0]       ctrl_q;
  logic                   sof_pulse, commit, cfg_clr, sticky;
  logic [N_CFG*REG_W-1:0] staged, active;
  logic [REG_W-1:0]       rd_mux, rdata_q;

  shadow_decode #(
    .ADDR_W(ADDR_W), .H_WORDS(H_WORDS), .V_WORDS(V_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(addr_i), .kind_o(kind), .idx_o(idx)
  );

  shadow_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .ctrl_wr_i  (wr_en_i && kind == K_CTRL),
    .stat_rd_i  (rd_en_i && kind == K_STAT),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl_q),
    .sof_pulse_o(sof_pulse),
    .commit_o   (commit),
    .cfg_clr_o  (cfg_clr),
    .core_rst_o (core_rst_o),
    .sticky_o   (sticky)
  );

  shadow_bank #(
    .N(N_CFG), .W(REG_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_clr),
    .wr_i    (wr_en_i && kind == K_CFG),
    .widx_i  (idx),
    .wdata_i (wdata_i),
    .commit_i(commit),
    .staged_o(staged),
    .active_o(active)
  );

  always_comb begin
    unique case (kind)
      K_CTRL:  rd_mux = ctrl_q;
      K_STAT:  rd_mux = {30'd0, sticky, ctrl_q[CB_EN]};
      K_VER:   rd_mux = VERSION_ID;
      K_CFG:   rd_mux = staged[idx*REG_W +: REG_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o      = rdata_q;
  assign enable_o     = ctrl_q[CB_EN];
  assign frame_size_o = active[0 +: REG_W];
  assign encoding_o   = active[REG_W +: REG_W];
  assign hcoef_o      = active[2*REG_W +: HC_BITS];
  assign vcoef_o      = active[2*REG_W + HC_BITS +: VC_BITS];
endmodule

// File: rtl/shadow_regs_chk.sv
module shadow_regs_chk #(
  parameter int unsigned HC_BITS = 1536,
  parameter int unsigned VC_BITS = 512
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        ctrl_i,
  input logic               sof_pulse_i,
  input logic               commit_i,
  input logic               clr_i,
  input logic               sticky_i,
  input logic               core_rst_i,
  input logic [31:0]        stg_size_i,
  input logic [31:0]        frame_size_i,
  input logic [31:0]        encoding_i,
  input logic [HC_BITS-1:0] hcoef_i,
  input logic [VC_BITS-1:0] vcoef_i
);
  AST_COMMIT_TAKES_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> frame_size_i == $past(stg_size_i)); // R3

  AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clr_i) |=> ($stable(frame_size_i) && $stable(encoding_i)
                               && $stable(hcoef_i) && $stable(vcoef_i))); // R4

  AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i); // R5

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[31] |=> (frame_size_i == '0 && encoding_i == '0 && hcoef_i == '0
                    && vcoef_i == '0)); // R6

  AST_HOLD_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[31] |-> core_rst_i); // R6

  AST_FSYNC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[30] && sof_pulse_i) |=> (ctrl_i == '0 && core_rst_i)); // R7

  AST_FSYNC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_i && !ctrl_i[31]) |=> !core_rst_i); // R7

  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> sticky_i); // R8
endmodule

bind frame_shadow_regs shadow_regs_chk #(
  .HC_BITS(HC_BITS), .VC_BITS(VC_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_q),
  .sof_pulse_i (sof_pulse),
  .commit_i    (commit),
  .clr_i       (cfg_clr),
  .sticky_i    (sticky),
  .core_rst_i  (core_rst_o),
  .stg_size_i  (staged[31:0]),
  .frame_size_i(frame_size_o),
  .encoding_i  (encoding_o),
  .hcoef_i     (hcoef_o),
  .vcoef_i     (vcoef_o)
);

// File: tb/sim_frame_shadow_regs.sv
module sim_frame_shadow_regs;
  localparam int CLK_P = 10;
  localparam int NCFG  = 66;
  localparam logic [31:0] VER = 32'h0300_0001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, rd_en = 0, sof = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        en_o, crst_o;
  logic [31:0] fsize_o, enc_o;
  logic [1535:0] hco_o;
  logic [511:0]  vco_o;

  int total = 0, bad = 0;
  logic [31:0] exp_stg [NCFG];
  logic [31:0] exp_act [NCFG];
  logic [31:0] exp_ctrl;

  always #(CLK_P/2) clk = ~clk;

  frame_shadow_regs #(.VERSION_ID(VER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sof_i(sof),
    .enable_o(en_o), .core_rst_o(crst_o), .frame_size_o(fsize_o),
    .encoding_o(enc_o), .hcoef_o(hco_o), .vcoef_o(vco_o)
  );

  function automatic logic [11:0] cfg_addr(int i);
    if (i == 0) return 12'h020;
    if (i == 1) return 12'h028;
    if (i < 50) return 12'(12'h100 + (i - 2) * 4);
    return 12'(12'h1C0 + (i - 50) * 4);
  endfunction

  function automatic logic [31:0] act_word(int i);
    if (i == 0) return fsize_o;
    if (i == 1) return enc_o;
    if (i < 50) return hco_o[(i-2)*32 +: 32];
    return vco_o[(i-50)*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    sof = 1;
    @(negedge clk);
    sof = 0;
  endtask

  // model: write to a configuration word
  task automatic cfg_wr(int i, logic [31:0] d);
    wr(cfg_addr(i), d);
    if (!exp_ctrl[31]) exp_stg[i] = d;
  endtask

  task automatic sof_model();
    pulse_sof();
    if (exp_ctrl[0] && exp_ctrl[1] && !exp_ctrl[30] && !exp_ctrl[31])
      for (int i = 0; i < NCFG; i++) exp_act[i] = exp_stg[i];
  endtask

  task automatic cmp_active(string req);
    for (int i = 0; i < NCFG; i++) chk(req, act_word(i), exp_act[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < NCFG; i++) begin exp_stg[i] = 0; exp_act[i] = 0; end
    exp_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 enable", {31'd0, en_o}, 0);
    chk("R1 core_rst", {31'd0, crst_o}, 0);
    cmp_active("R1 active");
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h004, d); chk("R1 status", d, 0);
    rd(12'h010, d); chk("R9 version", d, VER);

    // R2/R10 write every word, read back; outputs stay zero
    for (int i = 0; i < NCFG; i++) cfg_wr(i, 32'hA500_0000 | (i * 32'h0001_0101));
    for (int i = 0; i < NCFG; i++) begin
      rd(cfg_addr(i), d);
      chk("R2 R10 staged readback", d, exp_stg[i]);
    end
    sof_model();
    cmp_active("R4 ctrl off");

    // R4 enable only, permit only
    wr(12'h000, 32'h1); exp_ctrl = 1;
    sof_model(); cmp_active("R4 enable only");
    wr(12'h000, 32'h2); exp_ctrl = 2;
    sof_model(); cmp_active("R4 permit only");

    // R3 commit, R8 sticky
    wr(12'h000, 32'h3); exp_ctrl = 3;
    sof_model(); cmp_active("R3 commit");
    rd(12'h004, d); chk("R8 status set", d, 3);
    rd(12'h004, d); chk("R8 status cleared", d, 1);

    // R5 sof held high
    @(negedge clk); sof = 1;
    for (int i = 0; i < NCFG; i++) exp_act[i] = exp_stg[i];
    @(negedge clk);
    wr(cfg_addr(0), 32'hDEAD_0001); exp_stg[0] = 32'hDEAD_0001;
    repeat (4) @(negedge clk);
    chk("R5 held level no commit", fsize_o, exp_act[0]);
    sof = 0;
    sof_model();
    chk("R5 next edge commits", fsize_o, 32'hDEAD_0001);

    // random mix
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 1 + int'($urandom_range(4)); k++)
        cfg_wr(int'($urandom_range(NCFG - 1)), $urandom);
      if ($urandom_range(3) == 0) wr(12'h300 + 12'($urandom_range(15) * 4), $urandom);
      exp_ctrl = {30'd0, 2'($urandom_range(3))};
      wr(12'h000, exp_ctrl);
      sof_model();
      chk("R3 R4 random fsize", fsize_o, exp_act[0]);
      chk("R3 R4 random enc", enc_o, exp_act[1]);
      chk("R3 R4 random hcoef", act_word(2 + it), exp_act[2 + it]);
      chk("R3 R4 random vcoef", act_word(50 + it % 16), exp_act[50 + it % 16]);
    end
    cmp_active("R3 R4 random full");

    // R9 unmapped and control mask
    wr(12'h030, 32'h1234_5678); rd(12'h030, d); chk("R9 unmapped 030", d, 0);
    wr(12'h204, 32'h1234_5678); rd(12'h204, d); chk("R9 unmapped 204", d, 0);
    rd(12'h008, d); chk("R10 error word zero", d, 0);
    rd(12'h00C, d); chk("R10 irq word zero", d, 0);
    wr(12'h000, 32'h3FFF_FFFC); rd(12'h000, d); chk("R9 ctrl mask", d, 0);
    wr(12'h000, 32'h0000_0FF3); exp_ctrl = 3; rd(12'h000, d); chk("R9 ctrl keep", d, 3);
    chk("R8 enable_o", {31'd0, en_o}, 1);
    cmp_active("R9 no side effect");

    // R6 immediate reset
    wr(12'h000, 32'h8000_0000); exp_ctrl = 32'h8000_0000;
    chk("R6 core_rst high", {31'd0, crst_o}, 1);
    @(negedge clk);
    for (int i = 0; i < NCFG; i++) begin exp_stg[i] = 0; exp_act[i] = 0; end
    cmp_active("R6 active cleared");
    cfg_wr(5, 32'h5555_AAAA);
    rd(cfg_addr(5), d); chk("R6 write dropped", d, 0);
    rd(cfg_addr(0), d); chk("R6 staged cleared", d, 0);
    wr(12'h000, 32'h0); exp_ctrl = 0;
    chk("R6 release", {31'd0, crst_o}, 0);

    // R7 frame-aligned reset
    for (int i = 0; i < NCFG; i++) cfg_wr(i, 32'h7000_0000 + i);
    wr(12'h000, 32'h3); exp_ctrl = 3;
    sof_model();
    wr(12'h000, 32'h4000_0003); exp_ctrl = 32'h4000_0003;
    repeat (3) @(negedge clk);
    chk("R7 waits for frame", {31'd0, crst_o}, 0);
    chk("R7 active kept", fsize_o, 32'h7000_0000);
    pulse_sof();
    chk("R7 pulse", {31'd0, crst_o}, 1);
    for (int i = 0; i < NCFG; i++) begin exp_stg[i] = 0; exp_act[i] = 0; end
    exp_ctrl = 0;
    cmp_active("R7 active cleared");
    rd(12'h000, d); chk("R7 ctrl zero", d, 0);
    chk("R7 pulse ended", {31'd0, crst_o}, 0);
    rd(cfg_addr(9), d); chk("R7 staged cleared", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule